// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block drives one pulse-width-modulated output. The period is a register value. The active (high) length of every full period comes from a small queue of duty samples that software writes through a simple register interface. One sample is taken from the queue at the start of each period. When the queue is empty, the last sample taken is used again. A prescaler divides the system clock into counter ticks. A clock-select field gates the counter: a zero selection stops it, and either non-zero selection lets it run.

A write into the queue while it is full is lost and raises a sticky write-error flag. While that flag is set, the generator does not leave its stopped state, even if the enable bit is set. The flag can be cleared in two ways. Software can write a one to it, or software can issue a software reset by writing bit 3 of the control register. The reset empties the queue, returns every register to its default and holds bit 3 readable as one for a fixed number of cycles, so software can poll for completion.

A three-state machine controls the generator:
- **IDLE**: stopped, output low, counter at zero.
- **RUN**: counting and driving the output.
- **SRST**: software reset in progress.

The transitions are:
- **IDLE→RUN** when enabled with no write error. This transition also takes the first sample.
- **RUN→IDLE** when the enable bit is cleared.
- **IDLE/RUN→SRST** on a control write with bit 3 set.
- **SRST→IDLE** after `SWR_CYCLES` cycles.

Top module: `pwm_sample_gen`

Register addresses: 0 is control, 1 is status, 2 is the sample write port, and 3 is the period.

Control register fields:
- bit 0: enable
- bit 3: software reset
- bits 15:4: prescaler
- bits 17:16: clock select
- bit 22: debug-run

Status register fields:
- bits 2:0: queue fill level
- bit 4: write error

Reads of the sample port return zero.

## Requirements
- R1: After reset, control reads 0, status reads 0, the period register reads `PERIOD_RST`, and `pwm_out` is low.
- R2: Each write to address 2 while the queue holds fewer than `FIFO_DEPTH` entries appends its low 16 bits, and status bits 2:0 show the number of queued entries.
- R3: A write to address 2 while the queue is full is dropped, the level stays at `FIFO_DEPTH`, and status bit 4 is set.
- R4: While status bit 4 is set, setting control bit 0 leaves the machine in IDLE, `pwm_out` stays low, and control bit 0 still reads back as 1.
- R5: Writing status with bit 4 = 1 clears the error; writing it with bit 4 = 0 leaves the error unchanged.
- R6: In RUN the counter steps 0..period and wraps, so a period lasts period+1 ticks; `pwm_out` is high while the counter is below the active sample. A sample of 0 gives a constant low output, and a sample above the period gives a constant high output.
- R7: Entering RUN takes one sample, and each counter wrap takes the next one if the queue is non-empty; otherwise the current sample is reused.
- R8: The counter advances once every prescaler+1 clock cycles, using the prescaler in control bits 15:4.
- R9: With clock select (control bits 17:16) equal to 0 the counter does not advance and `pwm_out` holds its level; values 1 and 2 both let it count.
- R10: A control write with bit 3 = 1 empties the queue, clears the error, and restores the control and period registers to their defaults. Control bit 3 reads 1 for exactly `SWR_CYCLES` cycles, during which all register writes are ignored; the machine then returns to IDLE.
- R11: Control bit 22 is stored and read back and has no effect on the waveform.
- R12: Clearing control bit 0 returns the machine to IDLE with `pwm_out` low, and the queued samples are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with a queue of four 16-bit entries, a 12-bit prescaler, a four-cycle software reset and a default period of 9. It also programs a period of 4, so each period spans only a handful of clocks. With these values, the tests can reach the following cases within a few hundred cycles:
- several full queue cycles, including overflow;
- reuse of the last sample after the queue drains;
- the prescaler stretching each tick;
- the whole software-reset window.

// File: rtl/pwm_sample_pkg.sv
package pwm_sample_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SRST = 2'd2
    } pwm_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_SAMP = 2'd2;
    localparam logic [1:0] A_PER  = 2'd3;

    localparam int CB_EN   = 0;
    localparam int CB_SWR  = 3;
    localparam int CB_PRE  = 4;
    localparam int CB_CLK  = 16;
    localparam int CB_DBG  = 22;
    localparam int SB_ERR  = 4;
    localparam int CSEL_W  = 2;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            level <= '0;
        end else if (clr) begin
            rd_q  <= '0;
            wr_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clr |=> full);

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRESC_W = 12,
    parameter int CSEL_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    input  logic [CSEL_W-1:0]  clk_sel,
    output logic               tick
);

    logic [PRESC_W-1:0] pre_q;
    logic               clk_on;

    assign clk_on = (clk_sel != '0);
    assign tick   = run && clk_on && (pre_q == presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else if (clk_on) begin
            pre_q <= (pre_q == presc) ? '0 : pre_q + 1'b1;
        end
    end

    // R8
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (presc != '0) |=> (pre_q == '0));

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic         have_sample,
    input  logic [W-1:0] sample,
    output logic         pop,
    output logic         wave
);

    logic [W-1:0] cnt_q, duty_q;
    logic         roll;

    assign roll = run && tick && (cnt_q == period);
    assign pop  = (start || roll) && have_sample && !clr;
    assign wave = run && (cnt_q < duty_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else if (start || roll) begin
            cnt_q <= '0;
            if (have_sample) duty_q <= sample;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
        end
    end

    // R6
    rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (cnt_q == '0));

    // R7
    reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll && !have_sample && !clr |=> $stable(duty_q));

endmodule

// File: rtl/pwm_sample_gen.sv
module pwm_sample_gen
    import pwm_sample_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int PRESC_W    = 12,
    parameter int SWR_CYCLES = 4,
    parameter logic [SAMPLE_W-1:0] PERIOD_RST = 99
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int SWR_W = $clog2(SWR_CYCLES + 1);

    pwm_state_e          state_q, state_d;
    logic [SWR_W-1:0]    swr_cnt_q;
    logic                en_q, dbg_q, err_q;
    logic [CSEL_W-1:0]   csel_q;
    logic [PRESC_W-1:0]  presc_q;
    logic [SAMPLE_W-1:0] period_q;

    logic in_srst, run, start, swr_req, wr_ok;
    logic samp_wr, tick, pop, fifo_full, fifo_empty;
    logic [SAMPLE_W-1:0] fifo_head;
    logic [LVL_W-1:0]    fifo_level;
    logic                unused_bits;

    assign unused_bits = ^{bus_wdata[31:23], bus_wdata[21:18]};

    // ---- decoded strobes ----
    assign in_srst = (state_q == ST_SRST);
    assign wr_ok   = bus_wr && !in_srst;
    assign swr_req = wr_ok && (bus_addr == A_CTRL) && bus_wdata[CB_SWR];
    assign samp_wr = wr_ok && (bus_addr == A_SAMP);

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swr_req)              state_d = ST_SRST;
                else if (en_q && !err_q)  state_d = ST_RUN;
            end
            ST_RUN: begin
                if (swr_req)              state_d = ST_SRST;
                else if (!en_q)           state_d = ST_IDLE;
            end
            ST_SRST: begin
                if (swr_cnt_q == SWR_W'(SWR_CYCLES - 1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---- state-derived outputs ----
    always_comb begin
        run   = (state_q == ST_RUN);
        start = (state_q == ST_IDLE) && (state_d == ST_RUN);
    end

    // ---- software reset window ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        swr_cnt_q <= '0;
        else if (swr_req)  swr_cnt_q <= '0;
        else if (in_srst)  swr_cnt_q <= swr_cnt_q + 1'b1;
    end

    // ---- registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            dbg_q    <= 1'b0;
            csel_q   <= '0;
            presc_q  <= '0;
            period_q <= PERIOD_RST;
            err_q    <= 1'b0;
        end else if (swr_req) begin
            en_q     <= 1'b0;
            dbg_q    <= 1'b0;
            csel_q   <= '0;
            presc_q  <= '0;
            period_q <= PERIOD_RST;
            err_q    <= 1'b0;
        end else if (wr_ok) begin
            unique case (bus_addr)
                A_CTRL: begin
                    en_q    <= bus_wdata[CB_EN];
                    dbg_q   <= bus_wdata[CB_DBG];
                    csel_q  <= bus_wdata[CB_CLK +: CSEL_W];
                    presc_q <= bus_wdata[CB_PRE +: PRESC_W];
                end
                A_STAT: if (bus_wdata[SB_ERR]) err_q <= 1'b0;
                A_SAMP: if (fifo_full) err_q <= 1'b1;
                A_PER:  period_q <= bus_wdata[SAMPLE_W-1:0];
                default: ;
            endcase
        end
    end

    // ---- read mux ----
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[CB_EN]               = en_q;
                bus_rdata[CB_SWR]              = in_srst;
                bus_rdata[CB_PRE +: PRESC_W]   = presc_q;
                bus_rdata[CB_CLK +: CSEL_W]    = csel_q;
                bus_rdata[CB_DBG]              = dbg_q;
            end
            A_STAT: begin
                bus_rdata[LVL_W-1:0] = fifo_level;
                bus_rdata[SB_ERR]    = err_q;
            end
            A_PER:   bus_rdata[SAMPLE_W-1:0] = period_q;
            default: bus_rdata = '0;
        endcase
    end

    // ---- datapath ----
    pwm_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (swr_req),
        .push  (samp_wr),
        .din   (bus_wdata[SAMPLE_W-1:0]),
        .pop   (pop),
        .dout  (fifo_head),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwm_tick_gen #(.PRESC_W(PRESC_W), .CSEL_W(CSEL_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .presc   (presc_q),
        .clk_sel (csel_q),
        .tick    (tick)
    );

    pwm_period_ctr #(.W(SAMPLE_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (swr_req),
        .start       (start),
        .run         (run),
        .tick        (tick),
        .period      (period_q),
        .have_sample (!fifo_empty),
        .sample      (fifo_head),
        .pop         (pop),
        .wave        (pwm_out)
    );

    // R4
    err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && err_q |=> (state_q != ST_RUN));

    // R10
    srst_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |-> (fifo_level == '0) && !err_q && !pwm_out);

    // R10
    srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |-> (swr_cnt_q < SWR_W'(SWR_CYCLES)));

    // R12
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !en_q && !swr_req |=> !pwm_out);

endmodule

// File: tb/pwm_sample_gen_test.sv
module pwm_sample_gen_test;

    localparam int DEPTH = 4;
    localparam int SWR   = 4;
    localparam logic [15:0] PRST = 16'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    always #2 clk = ~clk;

    pwm_sample_gen #(
        .SAMPLE_W(16), .FIFO_DEPTH(DEPTH), .PRESC_W(12),
        .SWR_CYCLES(SWR), .PERIOD_RST(PRST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    // ---- behavioural reference ----
    logic [15:0] m_q[$];
    int          m_state = 0;
    int          m_sr = 0;
    bit          m_en = 0, m_dbg = 0, m_err = 0;
    int          m_csel = 0, m_presc = 0, m_pre = 0;
    logic [15:0] m_cnt = 0, m_duty = 0, m_period = PRST;

    task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", t, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_rd(logic [1:0] a);
        case (a)
            2'd0: return 32'(m_en) | (32'(m_state == 2) << 3) | (32'(m_presc) << 4)
                         | (32'(m_csel) << 16) | (32'(m_dbg) << 22);
            2'd1: return 32'(m_q.size()) | (32'(m_err) << 4);
            2'd3: return 32'(m_period);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_state = 0; m_sr = 0; m_en = 0; m_dbg = 0; m_err = 0;
            m_csel = 0; m_presc = 0; m_pre = 0; m_cnt = 0; m_duty = 0; m_period = PRST;
        end else begin
            bit run, start, tick, roll, full, swr, wok;
            run   = (m_state == 1);
            wok   = bus_wr && (m_state != 2);
            swr   = wok && bus_addr == 2'd0 && bus_wdata[3];
            start = (m_state == 0) && m_en && !m_err;
            tick  = run && m_csel != 0 && m_pre == m_presc;
            roll  = tick && m_cnt == m_period;
            full  = (m_q.size() == DEPTH);
            if (swr) begin
                m_cnt = 0; m_duty = 0;
            end else if (start || roll) begin
                m_cnt = 0;
                if (m_q.size() > 0) m_duty = m_q[0];
            end else if (tick) m_cnt = m_cnt + 1;
            else if (!run) m_cnt = 0;
            if (swr) m_q.delete();
            else begin
                if ((start || roll) && m_q.size() > 0) void'(m_q.pop_front());
                if (wok && bus_addr == 2'd2 && !full) m_q.push_back(bus_wdata[15:0]);
            end
            if (!run) m_pre = 0;
            else if (m_csel != 0) m_pre = (m_pre == m_presc) ? 0 : m_pre + 1;
            if (swr) begin m_state = 2; m_sr = 0; end
            else if (m_state == 2) begin
                if (m_sr == SWR - 1) m_state = 0; else m_sr++;
            end else if (m_state == 0) begin
                if (start) m_state = 1;
            end else if (!m_en) m_state = 0;
            if (swr) begin
                m_en = 0; m_dbg = 0; m_csel = 0; m_presc = 0; m_period = PRST; m_err = 0;
            end else if (wok) begin
                case (bus_addr)
                    2'd0: begin
                        m_en = bus_wdata[0]; m_dbg = bus_wdata[22];
                        m_csel = int'(bus_wdata[17:16]); m_presc = int'(bus_wdata[15:4]);
                    end
                    2'd1: if (bus_wdata[4]) m_err = 0;
                    2'd2: if (full) m_err = 1;
                    default: m_period = bus_wdata[15:0];
                endcase
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({tag, " wave"}, 32'(pwm_out), 32'(m_state == 1 && m_cnt < m_duty));
            chk({tag, " read"}, bus_rdata, m_rd(bus_addr));
        end
    end

    task automatic go(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
    endtask

    task automatic count_high(int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL R1 watchdog got=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int hi;
        go(3);
        rst_n = 1'b1;
        // R1 reset values
        tag = "R1";
        peek(2'd0, v); chk("R1 ctrl", v, 32'h0);
        peek(2'd1, v); chk("R1 status", v, 32'h0);
        peek(2'd3, v); chk("R1 period", v, 32'd9);
        chk("R1 pwm", 32'(pwm_out), 32'd0);
        // R2 fill the queue
        tag = "R2";
        wr(2'd3, 32'd4);
        wr(2'd2, 32'd2); wr(2'd2, 32'd0); wr(2'd2, 32'd5);
        peek(2'd1, v); chk("R2 level3", v, 32'h3);
        wr(2'd2, 32'd1);
        peek(2'd1, v); chk("R2 level4", v, 32'h4);
        // R3 overflow
        tag = "R3";
        wr(2'd2, 32'd7);
        peek(2'd1, v); chk("R3 err+full", v, 32'h14);
        // R4 enable blocked by error
        tag = "R4";
        wr(2'd0, 32'h0001_0001);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); chk("R4 held low", 32'(pwm_out), 32'd0);
        end
        @(posedge clk); #1;
        peek(2'd0, v); chk("R4 en readback", v, 32'h0001_0001);
        // R5 clearing the error
        tag = "R5";
        wr(2'd1, 32'h0);
        peek(2'd1, v); chk("R5 zero write keeps err", v, 32'h14);
        wr(2'd1, 32'h10);
        peek(2'd1, v); chk("R5 err cleared", v, 32'h04);
        // R6 / R7 waveform from samples 2,0,5,1 with period 4
        tag = "R6";
        go(30);
        tag = "R7";
        go(20);
        peek(2'd1, v); chk("R7 queue drained", v, 32'h0);
        count_high(10, hi); chk("R7 R6 last sample reused", 32'(hi), 32'd2);
        // R8 prescaler 2, sample 3
        tag = "R8";
        wr(2'd0, 32'h0001_0021);
        wr(2'd2, 32'd3);
        go(40);
        count_high(30, hi); chk("R8 stretched duty", 32'(hi), 32'd18);
        // R9 clock select 0 freezes
        tag = "R9";
        wr(2'd0, 32'h0000_0021);
        go(2);
        begin
            logic lvl;
            @(negedge clk); lvl = pwm_out;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk); chk("R9 frozen", 32'(pwm_out), 32'(lvl));
            end
            @(posedge clk); #1;
        end
        // R11 debug bit
        tag = "R11";
        wr(2'd0, 32'h0041_0001);
        peek(2'd0, v); chk("R11 dbg readback", v, 32'h0041_0001);
        go(20);
        // R12 disable
        tag = "R12";
        wr(2'd0, 32'h0001_0000);
        go(1);
        @(negedge clk); chk("R12 low when off", 32'(pwm_out), 32'd0);
        @(posedge clk); #1;
        wr(2'd2, 32'd4); wr(2'd2, 32'd4);
        go(3);
        peek(2'd1, v); chk("R12 samples kept", v, 32'h2);
        // R10 software reset
        tag = "R10";
        wr(2'd0, 32'h0000_0009);
        peek(2'd0, v); chk("R10 busy bit", v, 32'h8);
        wr(2'd3, 32'h55);
        go(4);
        peek(2'd0, v); chk("R10 ctrl default", v, 32'h0);
        peek(2'd1, v); chk("R10 status cleared", v, 32'h0);
        peek(2'd3, v); chk("R10 period default", v, 32'd9);
        go(2);
        finish_run();
    end

endmodule